// File: doc/BRIEF.md
# Biphase Mark Sampling Decoder

This block recovers a bit stream from a biphase mark line using a local receive clock that has no phase relation to the sender. The line passes through a two-stage synchroniser, and the synchronised value, taken once per receive clock, is the only sample the decision logic sees. While idle, the decoder compares each sample with a stored reference level. A mismatch marks the start of a cell. The decoder then copies the new level into the reference and counts a fixed sampling distance of `SAMPLE` cycles.

On the decision tick, the decoder compares the current sample with the reference. It reports a 0 when the two match and a 1 when they differ. It then loads that sample into the reference and goes back to searching for the next cell edge. Each decoded bit appears with a one-cycle valid strobe. If the consumer is not ready when a bit is decided, a sticky overrun flag is raised.

`SAMPLE` must be larger than 3. For a mark subcell of `MARK` cycles, a cell of `CELL` cycles, a clock ratio rho and an edge settling time E, the block decodes correctly only when (SAMPLE-1)*rho > MARK+E and CELL*rho > SAMPLE+2+E hold. Typical pairs are: mark 8 / cell 16 with SAMPLE 11, mark 7 / cell 14 with SAMPLE 10, and mark 16 / cell 32 with SAMPLE 23.

Top module: `bmDecoder`

## Requirements
- R1: After reset, outValid and overrun are 0 and the reference level is 0, so a line held low after reset produces no strobe.
- R2: While the synchronised sample equals the reference level, no strobe is produced, however long the line stays put.
- R3: When wireIn takes a level that differs from the reference, outValid rises on the (SAMPLE+3)th rising edge, counting the first edge that captures the new level as edge 1. Two strobes are always at least SAMPLE+1 cycles apart.
- R4: outBit is 0 when the sample on the decision tick equals the reference level, and 1 when it differs.
- R5: outValid is high for exactly one cycle per decoded bit, and outBit is valid in that cycle.
- R6: On the decision tick, the reference level takes the current sample. A line that then stays at that level starts no new cell.
- R7: Line changes while the decoder is counting do not restart the count. Only the sample on the decision tick affects the bit.
- R8: If consumerReady is low on the decision tick, overrun goes to 1 together with outValid. It stays at 1 until overrunClr is high at a clock edge, and a new overrun in that same cycle takes priority over the clear.
- R9: With a 16-cycle cell, an 8-cycle mark subcell and SAMPLE=11, any bit sequence is decoded in order with no missing and no extra bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wireIn | input | 1 | Biphase mark line, asynchronous to clk |
| consumerReady | input | 1 | Consumer can accept a bit this cycle |
| overrunClr | input | 1 | Clears the sticky overrun flag |
| outValid | output | 1 | One-cycle strobe for a decoded bit |
| outBit | output | 1 | Decoded bit value |
| overrun | output | 1 | Sticky flag: a bit was decided while the consumer was not ready |

## Verification
The bench counts the exact edge on which the strobe appears after a line transition. A counter that is off by one, or a missing synchroniser stage, therefore shows up as a latency of SAMPLE+2 or SAMPLE+4. A short glitch during counting has to yield exactly one bit of value 1 and then silence. A design that re-arms on mid-cell edges would emit extra bits. A design that fails to copy the decision sample into the reference would emit a spurious strobe on the next idle cycle. Streams of all zeros, all ones and alternating patterns test whether a 1 cell's mid-cell transition is wrongly taken as a new cell. The overrun tests check that the flag stays set without a clear and drops one edge after a clear.

// File: rtl/bmDecPkg.sv
package bmDecPkg;

  typedef enum logic {
    ST_SEEK  = 1'b0,
    ST_COUNT = 1'b1
  } decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic refLoad;
    logic cntClear;
    logic cntInc;
    logic decide;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic cntDone;
  } dpStatus_t;

endpackage

// File: rtl/bmDecDatapath.sv
module bmDecDatapath
  import bmDecPkg::*;
#(
  parameter int SAMPLE      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wireIn,
  input  logic        consumerReady,
  input  logic        overrunClr,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        outValid,
  output logic        outBit,
  output logic        overrun
);

  localparam int CNT_W    = (SAMPLE > 2) ? $clog2(SAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampleNow;
  logic                   refLevel;
  logic [CNT_W-1:0]       cnt;

  // synchroniser chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= wireIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign sampleNow = syncQ[SYNC_STAGES-1];

  // tracked reference level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               refLevel <= 1'b0;
    else if (strobe.refLoad) refLevel <= sampleNow;
  end

  // sampling distance counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign status.edgeSeen = sampleNow != refLevel;
  assign status.cntDone  = cnt == CNT_LAST;

  // output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= strobe.decide;
      if (strobe.decide) outBit <= sampleNow ^ refLevel;
    end
  end

  // sticky overrun, new event wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                overrun <= 1'b0;
    else if (strobe.decide && !consumerReady) overrun <= 1'b1;
    else if (overrunClr)                      overrun <= 1'b0;
  end

endmodule

// File: rtl/bmDecControl.sv
module bmDecControl
  import bmDecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);

  decState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_SEEK: begin
        if (status.edgeSeen) begin
          strobe.refLoad  = 1'b1;
          strobe.cntClear = 1'b1;
          stateD          = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (status.cntDone) begin
          strobe.decide  = 1'b1;
          strobe.refLoad = 1'b1;
          stateD         = ST_SEEK;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateD = ST_SEEK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_SEEK;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/bmDecoder.sv
module bmDecoder
  import bmDecPkg::*;
#(
  parameter int SAMPLE = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic wireIn,
  input  logic consumerReady,
  input  logic overrunClr,
  output logic outValid,
  output logic outBit,
  output logic overrun
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  bmDecControl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  bmDecDatapath #(
    .SAMPLE      (SAMPLE),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wireIn        (wireIn),
    .consumerReady (consumerReady),
    .overrunClr    (overrunClr),
    .strobe        (strobe),
    .status        (status),
    .outValid      (outValid),
    .outBit        (outBit),
    .overrun       (overrun)
  );

endmodule

// File: rtl/bmDecoderChk.sv
module bmDecoderChk #(
  parameter int SAMPLE = 11
) (
  input logic clk,
  input logic rstN,
  input logic consumerReady,
  input logic overrunClr,
  input logic outValid,
  input logic overrun
);

  localparam int GAP_W = $clog2(SAMPLE + 1) + 1;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         gapCnt <= '0;
    else if (outValid)                 gapCnt <= '0;
    else if (gapCnt != GAP_W'(SAMPLE)) gapCnt <= gapCnt + 1'b1;
  end

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> gapCnt == GAP_W'(SAMPLE));

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(consumerReady) |-> overrun);

  // R8
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !overrunClr |=> overrun);

  // R8
  overrun_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overrun) |-> $past(overrunClr));

  // R8
  overrun_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> outValid);

endmodule

bind bmDecoder bmDecoderChk #(.SAMPLE(SAMPLE)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .consumerReady (consumerReady),
  .overrunClr    (overrunClr),
  .outValid      (outValid),
  .overrun       (overrun)
);

// File: tb/bmDecoder_tb.sv
module bmDecoder_tb;

  localparam int SAMPLE = 11;
  localparam int HALF   = 8;   // mark subcell, cell is 2*HALF
  localparam int NPAT   = 6;
  localparam logic [7:0] PATS [NPAT] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wireIn = 1'b0;
  logic consumerReady = 1'b1;
  logic overrunClr = 1'b0;
  logic outValid, outBit, overrun;

  int tests = 0;
  int fails = 0;
  int rxCount = 0;
  logic rxBits [64];
  logic lvl = 1'b0;

  always #10 clk = ~clk;

  bmDecoder #(.SAMPLE(SAMPLE)) u_dut (
    .clk(clk), .rstN(rstN), .wireIn(wireIn), .consumerReady(consumerReady),
    .overrunClr(overrunClr), .outValid(outValid), .outBit(outBit), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (outValid && rxCount < 64) begin
      rxBits[rxCount] = outBit;
      rxCount = rxCount + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    lvl = ~lvl; wireIn = lvl;
    repeat (HALF - 1) @(negedge clk);
    @(negedge clk);
    if (b) begin lvl = ~lvl; wireIn = lvl; end
    repeat (HALF - 1) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outValid", outValid, 0);
    chk("R1 overrun", overrun, 0);

    // R2 line held at reference level
    rxCount = 0;
    idle(40);
    chk("R2 idle low strobes", rxCount, 0);

    // R3 latency and R4 bit 0 when level is kept
    rxCount = 0;
    lvl = 1'b1; wireIn = 1'b1;
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (outValid || k > 100) break;
    end
    chk("R3 latency edges", k, SAMPLE + 3);
    chk("R4 kept level bit", outBit, 0);
    @(negedge clk);
    chk("R5 strobe width", outValid, 0);
    idle(30);
    chk("R2 idle high strobes", rxCount, 1);

    // R7 glitch during counting, R6 re-arm to decided level
    rxCount = 0;
    lvl = ~lvl; wireIn = lvl;
    idle(3);
    lvl = ~lvl; wireIn = lvl;
    idle(40);
    chk("R7 glitch strobe count", rxCount, 1);
    chk("R7 glitch bit", rxBits[0], 1);
    rxCount = 0;
    idle(30);
    chk("R6 no strobe after re-arm", rxCount, 0);

    // R9 stream table, LSB first
    for (int p = 0; p < NPAT; p++) begin
      rxCount = 0;
      for (int b = 0; b < 8; b++) sendBit(PATS[p][b]);
      idle(8);
      chk("R9 bit count", rxCount, 8);
      for (int b = 0; b < 8; b++)
        chk($sformatf("R9 pattern %0d bit %0d", p, b), rxBits[b], PATS[p][b]);
    end

    // R8 overrun
    consumerReady = 1'b0;
    rxCount = 0;
    sendBit(1'b1);
    idle(6);
    consumerReady = 1'b1;
    chk("R8 overrun set", overrun, 1);
    chk("R4 differing level bit", rxBits[0], 1);
    idle(20);
    chk("R8 overrun held", overrun, 1);
    overrunClr = 1'b1;
    @(negedge clk);
    overrunClr = 1'b0;
    chk("R8 overrun cleared", overrun, 0);
    sendBit(1'b0);
    idle(6);
    chk("R8 no overrun when ready", overrun, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule